// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a simple processor core and decides which of a set of peripheral interrupt sources is serviced next. Each source is one of two kinds. Pulse sources latch into a pending flag. Level sources have no flag and request service only while their input is high. Every source has its own enable bit. A global enable bit, owned by the controller, gates all of them. Among the sources that are both enabled and requesting, the one with the lowest index wins. The controller then presents the address of that source's vector, which the core loads into its program counter.

The core talks to the controller through three handshakes. `irq_ack` means an interrupt was taken at an instruction boundary. `reti` means a handler has returned. `insn_retire` means a main-program instruction has completed. Software reaches the controller through a small write port, which serves three purposes: loading the enable mask, clearing flags by writing ones, and moving the vector table. The table can sit either at the bottom of program memory or at a boot-section base supplied on a pin. Moving it needs a timed unlock, and interrupts are held off while the unlock window is open.

The core is responsible for completing any multi-cycle instruction before it raises `irq_ack`, and for the clock counts of entry and return. The controller only decides when a request is eligible and where its vector lies.

Top module: `irq_vector_ctrl`

## Requirements
- R1: With the table select bit at 0, the vector for source i (counting from 0) is 2*(i+1). With it at 1, the vector is `boot_base` + 2*(i+1). Examples: source 5 gives 0x000C, and source 24 gives 0x0032.
- R2: When several enabled sources request at once, the source with the lowest index is presented.
- R3: A pulse on a pulse-type source sets its flag whether or not the source or the global enable is set. The flag is serviced once both enables allow it.
- R4: The write port has three codes: address 0 loads the enable mask, address 1 clears flags, and address 2 writes control. An address-1 write clears each flag whose data bit is 1. No write ever sets a flag. Taking a vector with `irq_ack` clears that source's flag.
- R5: Level sources (bits set in LEVEL_MASK, by default sources 0 and 1) keep no flag. They request only while `req_in` is high. A level request that drops while the source is disabled is never serviced.
- R6: `irq_ack` while `irq_valid` is high clears `gie`. `reti` sets `gie`. `gie_clr` clears `gie`, and `gie_set` sets it, which lets a handler allow nesting.
- R7: After `reti`, no request is presented until one `insn_retire` pulse has been seen.
- R8: The flag of source SW_ONLY_IDX (default 23) is not cleared by taking its vector. Only an address-1 write clears it.
- R9: A control write with bit 1 set opens a window of UNLOCK_CLKS (default 4) cycles. A control write with bit 1 clear inside the window loads bit 0 as the table select and closes the window. Such a write outside the window is ignored. `irq_valid` stays low while the window is open.
- R10: After reset, `gie` is low, all flags and enables are zero, and the table select is 0. Whenever `irq_valid` is low, `irq_vec` is zero and `idle` is high.
- R11: A source whose enable bit is 0 is never presented, even if it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | NUM_SRC | Source requests: single-cycle pulses for pulse sources, levels for level sources |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | 0 = enable mask, 1 = flag clear, 2 = control |
| cfg_wdata | input | NUM_SRC | Write data; for control, bit 0 is the table select and bit 1 is the change-enable |
| boot_base | input | ADDR_W | Boot-section base address |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| irq_ack | input | 1 | Core takes the presented interrupt |
| reti | input | 1 | Core returns from a handler |
| insn_retire | input | 1 | Core retired one main-program instruction |
| irq_valid | output | 1 | A request is eligible for acceptance |
| irq_vec | output | ADDR_W | Vector address of the presented request, zero when idle |
| idle | output | 1 | No request is eligible |
| gie | output | 1 | Global interrupt enable |
| flags | output | NUM_SRC | Pending flags, always zero for level sources |

## Verification
The assertions assume that `irq_ack` is raised only while `irq_valid` is high. They also assume the core never raises `reti`, `irq_ack` or the global-enable strobes in the same cycle as one another. The gie checks depend on that, because the controller resolves such overlaps by a fixed order the bench does not exercise. The stimulus raises each handshake alone, for exactly one cycle, and only after sampling `irq_valid`. Pulse sources are driven for a single cycle, and level sources are held steady across each sample point.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    CFG_ENABLE  = 2'd0,
    CFG_FLAGCLR = 2'd1,
    CFG_CONTROL = 2'd2,
    CFG_SPARE   = 2'd3
  } cfg_sel_e;

  localparam int CTRL_SEL_BIT = 0;
  localparam int CTRL_CHG_BIT = 1;
endpackage

// File: rtl/ivc_src_bank.sv
module ivc_src_bank #(
  parameter int                 N           = 25,
  parameter logic [N-1:0]       LEVEL_MASK  = {{(N-2){1'b0}}, 2'b11},
  parameter int                 SW_ONLY_IDX = 23
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic [N-1:0] req_in,
  input  logic         en_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  input  logic         take,
  input  logic [N-1:0] grant,
  output logic [N-1:0] active,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] en_q;
  logic [N-1:0] en_d;
  logic         en_ce;

  always_comb begin
    en_ce = en_we;
    en_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign flag_q[i] = 1'b0;
      assign active[i] = req_in[i] & en_q[i];
    end else begin : g_event
      localparam bit KEEP_ON_TAKE = (i == SW_ONLY_IDX);
      logic flag_r;
      logic flag_d;
      logic flag_ce;
      always_comb begin
        flag_d = flag_r;
        if (clr_we && wdata[i])                  flag_d = 1'b0;
        if (take && grant[i] && !KEEP_ON_TAKE)   flag_d = 1'b0;
        if (req_in[i])                           flag_d = 1'b1;
        flag_ce = (flag_d != flag_r);
      end
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns)      flag_r <= 1'b0;
        else if (flag_ce) flag_r <= flag_d;
      end
      assign flag_q[i] = flag_r;
      assign active[i] = flag_r & en_q[i];
    end
  end

  AST_FLAG_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_ns)
    ((flag_q & ~$past(flag_q) & ~$past(req_in)) == '0)) else $error("flag rose without request"); // R4

  if (SW_ONLY_IDX < N && !LEVEL_MASK[SW_ONLY_IDX]) begin : g_sticky_chk
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_ns)
      (take && grant[SW_ONLY_IDX] && !(clr_we && wdata[SW_ONLY_IDX])) |=> flag_q[SW_ONLY_IDX])
      else $error("software-only flag cleared by acceptance"); // R8
  end
endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
  parameter int N  = 25,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (grant[k]) idx = idx | IW'(k);
    end
  end
endmodule

// File: rtl/ivc_vec_base.sv
module ivc_vec_base #(
  parameter int UNLOCK_CLKS = 4,
  parameter int CW          = $clog2(UNLOCK_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic ctrl_we,
  input  logic wr_sel,
  input  logic wr_chg,
  output logic sel_q,
  output logic win_open
);
  logic [CW-1:0] win_q, win_d;
  logic          sel_d, sel_ce, win_ce;

  assign win_open = (win_q != '0);

  always_comb begin
    sel_d  = sel_q;
    sel_ce = 1'b0;
    win_d  = win_open ? win_q - CW'(1) : win_q;
    if (ctrl_we && wr_chg) begin
      win_d = CW'(UNLOCK_CLKS);
    end else if (ctrl_we && win_open) begin
      sel_d  = wr_sel;
      sel_ce = 1'b1;
      win_d  = '0;
    end
    win_ce = (win_d != win_q);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     sel_q <= 1'b0;
    else if (sel_ce) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     win_q <= '0;
    else if (win_ce) win_q <= win_d;
  end

  AST_SEL_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_ns)
    !$past(win_open) |-> $stable(sel_q)) else $error("select moved outside window"); // R9
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int                   NUM_SRC     = 25,
  parameter int                   ADDR_W      = 16,
  parameter logic [NUM_SRC-1:0]   LEVEL_MASK  = {{(NUM_SRC-2){1'b0}}, 2'b11},
  parameter int                   SW_ONLY_IDX = 23,
  parameter int                   UNLOCK_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [NUM_SRC-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0]  boot_base,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               irq_ack,
  input  logic               reti,
  input  logic               insn_retire,
  output logic               irq_valid,
  output logic [ADDR_W-1:0]  irq_vec,
  output logic               idle,
  output logic               gie,
  output logic [NUM_SRC-1:0] flags
);
  import ivc_pkg::*;
  localparam int IW = $clog2(NUM_SRC);

  logic [1:0] rst_pipe;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  cfg_sel_e            cfg_sel;
  logic                en_we, clr_we, ctrl_we;
  logic [NUM_SRC-1:0]  active, grant;
  logic [IW-1:0]       win_idx;
  logic                any_active, sel_q, win_open, take;
  logic                hold_q, hold_d, hold_ce;
  logic                gie_q, gie_d, gie_ce;
  logic [ADDR_W-1:0]   origin, vec_sum;

  assign cfg_sel = cfg_sel_e'(cfg_addr);
  assign en_we   = cfg_we && (cfg_sel == CFG_ENABLE);
  assign clr_we  = cfg_we && (cfg_sel == CFG_FLAGCLR);
  assign ctrl_we = cfg_we && (cfg_sel == CFG_CONTROL);

  ivc_src_bank #(.N(NUM_SRC), .LEVEL_MASK(LEVEL_MASK), .SW_ONLY_IDX(SW_ONLY_IDX)) bank_i (
    .clk(clk), .rst_ns(rst_ns), .req_in(req_in), .en_we(en_we), .clr_we(clr_we),
    .wdata(cfg_wdata), .take(take), .grant(grant), .active(active), .flag_q(flags)
  );

  ivc_prio_pick #(.N(NUM_SRC), .IW(IW)) pick_i (
    .req(active), .any(any_active), .grant(grant), .idx(win_idx)
  );

  ivc_vec_base #(.UNLOCK_CLKS(UNLOCK_CLKS)) base_i (
    .clk(clk), .rst_ns(rst_ns), .ctrl_we(ctrl_we),
    .wr_sel(cfg_wdata[CTRL_SEL_BIT]), .wr_chg(cfg_wdata[CTRL_CHG_BIT]),
    .sel_q(sel_q), .win_open(win_open)
  );

  assign irq_valid = any_active && gie_q && !hold_q && !win_open;
  assign take      = irq_ack && irq_valid;
  assign idle      = !irq_valid;
  assign gie       = gie_q;

  always_comb begin
    origin  = sel_q ? boot_base : '0;
    vec_sum = origin + ADDR_W'({win_idx, 1'b0}) + ADDR_W'(2);
    irq_vec = irq_valid ? vec_sum : '0;
  end

  always_comb begin
    hold_d = hold_q;
    if (insn_retire) hold_d = 1'b0;
    if (reti)        hold_d = 1'b1;
    hold_ce = (hold_d != hold_q);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      hold_q <= 1'b0;
    else if (hold_ce) hold_q <= hold_d;
  end

  always_comb begin
    gie_d = gie_q;
    if (gie_set) gie_d = 1'b1;
    if (gie_clr) gie_d = 1'b0;
    if (reti)    gie_d = 1'b1;
    if (take)    gie_d = 1'b0;
    gie_ce = (gie_d != gie_q);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     gie_q <= 1'b0;
    else if (gie_ce) gie_q <= gie_d;
  end

  AST_GIE_DROP_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_ns)
    (irq_ack && irq_valid) |=> !gie) else $error("gie kept after acceptance"); // R6
  AST_GIE_UP_ON_RETI: assert property (@(posedge clk) disable iff (!rst_ns)
    (reti && !irq_ack && !gie_clr) |=> gie) else $error("gie not restored"); // R6
  AST_HOLD_AFTER_RETI: assert property (@(posedge clk) disable iff (!rst_ns)
    reti |=> !irq_valid) else $error("request presented before a retire"); // R7
  AST_WINDOW_MASKS: assert property (@(posedge clk) disable iff (!rst_ns)
    win_open |-> !irq_valid) else $error("request during unlock window"); // R9
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    !irq_valid |-> (irq_vec == '0 && idle)) else $error("nonzero vector while idle"); // R10
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int N = 25;
  localparam int AW = 16;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_in;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [N-1:0]  cfg_wdata;
  logic [AW-1:0] boot_base;
  logic          gie_set, gie_clr, irq_ack, reti, insn_retire;
  logic          irq_valid, idle, gie;
  logic [AW-1:0] irq_vec;
  logic [N-1:0]  flags;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .boot_base(boot_base), .gie_set(gie_set), .gie_clr(gie_clr),
    .irq_ack(irq_ack), .reti(reti), .insn_retire(insn_retire), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .idle(idle), .gie(gie), .flags(flags)
  );

  localparam int NROW = 6;
  localparam logic [N-1:0]  T_REQ [NROW] = '{25'h20, 25'h408, 25'h1000000, 25'h80, 25'h210, 25'h4};
  localparam logic [N-1:0]  T_EN  [NROW] = '{ALL, ALL, ALL, 25'h0, 25'h200, ALL};
  localparam logic          T_VAL [NROW] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [AW-1:0] T_VEC [NROW] = '{16'h000C, 16'h0008, 16'h0032, 16'h0000, 16'h0014, 16'h0006};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [N-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    req_in = m;
    step();
    req_in = '0;
  endtask

  task automatic strobe(input int which);
    case (which)
      0: irq_ack = 1'b1;
      1: reti = 1'b1;
      2: insn_retire = 1'b1;
      default: gie_set = 1'b1;
    endcase
    step();
    irq_ack = 1'b0; reti = 1'b0; insn_retire = 1'b0; gie_set = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    boot_base = 16'h7000; gie_set = 1'b0; gie_clr = 1'b0; irq_ack = 1'b0;
    reti = 1'b0; insn_retire = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R10 reset state
    chk("R10 valid", 32'(irq_valid), 0);
    chk("R10 vec", 32'(irq_vec), 0);
    chk("R10 idle", 32'(idle), 1);
    chk("R10 gie", 32'(gie), 0);
    chk("R10 flags", 32'(flags), 0);

    strobe(3);
    chk("R6 gie_set", 32'(gie), 1);

    // Table: R1 addressing, R2 priority, R11 enables
    for (int r = 0; r < NROW; r++) begin
      cfg_write(2'd1, ALL);
      cfg_write(2'd0, T_EN[r]);
      pulse_req(T_REQ[r]);
      chk($sformatf("R2 R11 row%0d valid", r), 32'(irq_valid), 32'(T_VAL[r]));
      chk($sformatf("R1 R2 row%0d vec", r), 32'(irq_vec), 32'(T_VEC[r]));
    end

    // R3 flag set while disabled, served once enabled
    cfg_write(2'd1, ALL);
    cfg_write(2'd0, '0);
    pulse_req(25'h40);
    chk("R3 flag while disabled", 32'(flags), 32'h40);
    chk("R11 disabled not presented", 32'(irq_valid), 0);
    cfg_write(2'd0, ALL);
    chk("R3 served after enable", 32'(irq_vec), 32'h000E);

    // R4/R6 acceptance
    strobe(0);
    chk("R4 flag cleared on take", 32'(flags), 0);
    chk("R6 gie cleared on take", 32'(gie), 0);

    // R7 retire hold
    pulse_req(25'h100);
    chk("R6 masked in handler", 32'(irq_valid), 0);
    strobe(1);
    chk("R6 reti sets gie", 32'(gie), 1);
    chk("R7 held after reti", 32'(irq_valid), 0);
    strobe(2);
    chk("R7 presented after retire", 32'(irq_vec), 32'h0012);

    // R6 nesting
    strobe(0);
    pulse_req(25'h8);
    chk("R6 no nest without gie", 32'(irq_valid), 0);
    strobe(3);
    chk("R6 nest after gie_set", 32'(irq_vec), 32'h0008);
    strobe(0);
    strobe(1);
    strobe(2);

    // R4 write-one clear, write-zero harmless
    cfg_write(2'd1, ALL);
    cfg_write(2'd0, '0);
    pulse_req(25'h3000);
    cfg_write(2'd1, 25'h1000);
    chk("R4 write-one clears", 32'(flags), 32'h2000);
    cfg_write(2'd1, '0);
    chk("R4 write-zero no effect", 32'(flags), 32'h2000);
    cfg_write(2'd1, ALL);
    chk("R4 clear all", 32'(flags), 0);

    // R8 software-only flag
    cfg_write(2'd0, ALL);
    pulse_req(25'h800000);
    chk("R8 vec", 32'(irq_vec), 32'h0030);
    strobe(0);
    chk("R8 flag kept on take", 32'(flags), 32'h800000);
    strobe(1);
    strobe(2);
    chk("R8 still presented", 32'(irq_vec), 32'h0030);
    cfg_write(2'd1, 25'h800000);
    chk("R8 cleared by software", 32'(irq_valid), 0);

    // R5 level sources
    cfg_write(2'd0, '0);
    req_in = 25'h1; step(); req_in = '0; step();
    chk("R5 no flag", 32'(flags), 0);
    cfg_write(2'd0, ALL);
    chk("R5 lost request", 32'(irq_valid), 0);
    req_in = 25'h3; step();
    chk("R5 R2 level vec", 32'(irq_vec), 32'h0002);
    req_in = 25'h2; step();
    chk("R5 second level", 32'(irq_vec), 32'h0004);
    req_in = '0; step();
    chk("R5 gone", 32'(irq_valid), 0);

    // R9 relocation
    pulse_req(25'h20);
    chk("R1 low table", 32'(irq_vec), 32'h000C);
    cfg_write(2'd2, 25'h2);
    chk("R9 masked in window", 32'(irq_valid), 0);
    cfg_write(2'd2, 25'h1);
    chk("R1 R9 boot table", 32'(irq_vec), 32'h700C);
    cfg_write(2'd2, 25'h2);
    repeat (5) step();
    chk("R9 window expired", 32'(irq_vec), 32'h700C);
    cfg_write(2'd2, 25'h0);
    chk("R9 late write ignored", 32'(irq_vec), 32'h700C);
    cfg_write(2'd2, 25'h2);
    cfg_write(2'd2, 25'h0);
    chk("R9 back to low table", 32'(irq_vec), 32'h000C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule